// File: doc/BRIEF.md
# Hit Record Formatter and Serializer

This block takes one pixel hit at a time from an array scanner and turns it into a fixed-length serial record. Each hit carries a 12-bit column address, a 14-bit row address and a 12-bit bunch-crossing time stamp. Every field gets two parity bits. The three protected fields are joined into one 44-bit record, which is shifted out on a single data line at one bit per clock. A 50 MHz bit clock is the target rate.

The scanner offers a hit with `in_valid`. The hit is taken on a clock edge where `in_ready` is also high. `in_ready` stays low while the record is being shifted, so the scanner is held off until the line is free. A frame strobe marks the first bit of every record, and the data line rests at 0 between records. A value above the legal range of its field sets a sticky error flag, but the record still carries the value unchanged.

Top module: `hit_record_serializer`

## Requirements
- R1: After reset `in_ready` is 1, `ser_data` and `ser_frame` are 0, and `range_err` is 0.
- R2: A record is 44 bits, sent most significant bit first. Its layout, from the first bit to the last, is: column data (12 bits), column parity (2), row data (14), row parity (2), time data (12), time parity (2). Each data field is sent MSB first.
- R3: Each field's two parity bits follow its data bits. The first parity bit is the XOR of the data bits at even positions (0, 2, 4, ...). The second is the XOR of the data bits at odd positions (1, 3, 5, ...).
- R4: The first record bit appears on `ser_data` in the cycle after the accepting edge. One further bit follows in each of the next 43 cycles.
- R5: `ser_frame` is 1 only during the first bit of each record.
- R6: `in_ready` is 0 for exactly 44 cycles after an acceptance and is 1 in the cycle that follows the last bit.
- R7: `in_valid` and the hit inputs have no effect while `in_ready` is 0. The record in flight is unchanged, and no extra record follows it.
- R8: While no record is being sent, `ser_data` and `ser_frame` are 0.
- R9: Accepting a column above 2200, a row above 12500 or a time above 3000 sets `range_err`. The flag stays set until reset. The out-of-range value is still sent unchanged.
- R10: Values exactly at 2200, 12500 and 3000 do not set `range_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Hit offered by the scanner |
| in_ready | output | 1 | Block can take a hit |
| in_col | input | 12 | Column address |
| in_row | input | 14 | Row address |
| in_time | input | 12 | Bunch-crossing time stamp |
| ser_data | output | 1 | Serial record bit |
| ser_frame | output | 1 | High on the first bit of a record |
| range_err | output | 1 | Sticky out-of-range flag |

## Verification
Two things can happen on the same edge: a record is loaded and the range error is captured. The bench provokes this by offering out-of-range columns, rows and times. It then judges both the flag and the bit-exact serial record that carries the illegal value.

Offers that arrive while the line is busy can also clash with the record in flight. To provoke this, the bench holds `in_valid` high with a different, out-of-range hit during every shift cycle. Three things are judged:
- the record still on the line,
- the `range_err` value,
- the absence of a second frame.

// File: rtl/hit_record_serializer.sv
module hit_record_serializer #(
  parameter int COL_W   = 12,
  parameter int ROW_W   = 14,
  parameter int TS_W    = 12,
  parameter int COL_MAX = 2200,
  parameter int ROW_MAX = 12500,
  parameter int TS_MAX  = 3000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [COL_W-1:0] in_col,
  input  logic [ROW_W-1:0] in_row,
  input  logic [TS_W-1:0]  in_time,
  output logic             ser_data,
  output logic             ser_frame,
  output logic             range_err
);
  localparam int REC_W = COL_W + ROW_W + TS_W + 6;
  localparam int CW    = $clog2(REC_W + 1);
  localparam int MW    = (ROW_W > COL_W) ? ((ROW_W > TS_W) ? ROW_W : TS_W)
                                         : ((COL_W > TS_W) ? COL_W : TS_W);
  localparam logic [COL_W-1:0] COL_LIM = COL_W'(COL_MAX);
  localparam logic [ROW_W-1:0] ROW_LIM = ROW_W'(ROW_MAX);
  localparam logic [TS_W-1:0]  TS_LIM  = TS_W'(TS_MAX);

  function automatic logic [1:0] par2(input logic [MW-1:0] d);
    logic pe, po;
    pe = 1'b0;
    po = 1'b0;
    for (int i = 0; i < MW; i += 2) pe ^= d[i];
    for (int i = 1; i < MW; i += 2) po ^= d[i];
    return {pe, po};
  endfunction

  logic [REC_W-1:0] shreg;
  logic [CW-1:0]    left;
  logic             busy, take, oor;
  logic [REC_W-1:0] rec;

  assign busy      = (left != '0);
  assign in_ready  = !busy;
  assign take      = in_valid && in_ready;
  assign oor       = (in_col > COL_LIM) || (in_row > ROW_LIM) || (in_time > TS_LIM);
  assign rec       = {in_col, par2(MW'(in_col)), in_row, par2(MW'(in_row)),
                      in_time, par2(MW'(in_time))};
  assign ser_data  = busy && shreg[REC_W-1];
  assign ser_frame = (left == CW'(REC_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= '0;
      left      <= '0;
      range_err <= 1'b0;
    end else if (take) begin
      shreg     <= rec;
      left      <= CW'(REC_W);
      range_err <= range_err | oor;
    end else if (busy) begin
      shreg <= {shreg[REC_W-2:0], 1'b0};
      left  <= left - 1'b1;
    end
  end
endmodule

module hit_record_serializer_chk #(
  parameter int REC_W = 44
) (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic ser_data,
  input logic ser_frame,
  input logic range_err
);
  localparam int NW = $clog2(REC_W + 2);
  logic [NW-1:0] lowcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lowcnt <= '0;
    else if (!in_ready) lowcnt <= lowcnt + 1'b1;
    else lowcnt <= '0;
  end

  p_frame_after_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (ser_frame && !in_ready));
  p_frame_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ser_frame |=> !ser_frame);
  p_ready_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> (lowcnt == NW'(REC_W)));
  p_no_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lowcnt <= NW'(REC_W));
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!ser_data && !ser_frame));
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    range_err |=> range_err);
endmodule

bind hit_record_serializer hit_record_serializer_chk #(.REC_W(REC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .ser_data(ser_data), .ser_frame(ser_frame), .range_err(range_err)
);

// File: tb/sim_hit_record_serializer.sv
module sim_hit_record_serializer;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [11:0] in_col = '0, in_time = '0;
  logic [13:0] in_row = '0;
  logic in_ready, ser_data, ser_frame, range_err;
  int vectors = 0, errs = 0;

  always #4 clk = ~clk;

  hit_record_serializer u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_col(in_col), .in_row(in_row), .in_time(in_time),
    .ser_data(ser_data), .ser_frame(ser_frame), .range_err(range_err)
  );

  function automatic logic [1:0] pp(input logic [15:0] d, input int w);
    logic a = 1'b0, b = 1'b0;
    for (int i = 0; i < w; i++) if (i % 2 == 0) a ^= d[i]; else b ^= d[i];
    return {a, b};
  endfunction

  function automatic logic [43:0] expect_rec(input logic [11:0] c, input logic [13:0] r,
                                             input logic [11:0] t);
    return {c, pp({4'b0, c}, 12), r, pp({2'b0, r}, 14), t, pp({4'b0, t}, 12)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_hit(input logic [11:0] c, input logic [13:0] r, input logic [11:0] t,
                         input bit noise);
    logic [43:0] got, fr, rdy;
    @(negedge clk);
    in_col = c; in_row = r; in_time = t; in_valid = 1'b1;
    @(posedge clk);
    for (int i = 43; i >= 0; i--) begin
      @(negedge clk);
      if (noise) begin
        in_valid = 1'b1; in_col = 12'hFFF; in_row = 14'h3FFF; in_time = 12'hFFF;
      end else in_valid = 1'b0;
      got[i] = ser_data; fr[i] = ser_frame; rdy[i] = in_ready;
    end
    chk(got == expect_rec(c, r, t), "R2/R3/R4/R7 record", 64'(got), 64'(expect_rec(c, r, t)));
    chk(fr == 44'h800_0000_0000, "R5 frame", 64'(fr), 64'h800_0000_0000);
    chk(rdy == '0, "R6 ready low", 64'(rdy), 64'h0);
    @(negedge clk);
    chk(in_ready == 1'b1, "R6 ready after last bit", 64'(in_ready), 64'h1);
    in_valid = 1'b0;
    chk(!ser_data && !ser_frame, "R8/R7 idle after record", 64'({ser_data, ser_frame}), 64'h0);
  endtask

  initial begin
    #(8 * 200000);
    errs++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(in_ready && !ser_data && !ser_frame && !range_err, "R1 during reset",
        64'({in_ready, ser_data, ser_frame, range_err}), 64'h8);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && !ser_data && !ser_frame && !range_err, "R1 after reset",
        64'({in_ready, ser_data, ser_frame, range_err}), 64'h8);
    repeat (4) begin
      @(negedge clk);
      chk(!ser_data && !ser_frame, "R8 idle line", 64'({ser_data, ser_frame}), 64'h0);
    end
    for (int i = 0; i < 12; i++) run_hit(12'(1 << i), 14'd0, 12'd0, 1'b0);
    for (int i = 0; i < 14; i++) run_hit(12'd0, 14'(1 << i), 12'd0, 1'b1);
    for (int i = 0; i < 12; i++) run_hit(12'd0, 14'd0, 12'(1 << i), 1'b1);
    for (int i = 0; i < 24; i++)
      run_hit(12'((i * 97 + 5) % 2201), 14'((i * 523 + 11) % 12501), 12'((i * 131 + 7) % 3001), 1'b1);
    run_hit(12'd2200, 14'd12500, 12'd3000, 1'b0);
    run_hit(12'd0, 14'd0, 12'd0, 1'b0);
    chk(range_err == 1'b0, "R10/R7 no error at limits", 64'(range_err), 64'h0);
    run_hit(12'd2201, 14'd5, 12'd5, 1'b0);
    chk(range_err == 1'b1, "R9 column over", 64'(range_err), 64'h1);
    run_hit(12'd1, 14'd1, 12'd1, 1'b0);
    chk(range_err == 1'b1, "R9 sticky", 64'(range_err), 64'h1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk(range_err == 1'b0, "R1 reset clears flag", 64'(range_err), 64'h0);
    run_hit(12'd3, 14'd12501, 12'd3, 1'b0);
    chk(range_err == 1'b1, "R9 row over", 64'(range_err), 64'h1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    run_hit(12'd3, 14'd3, 12'd3001, 1'b0);
    chk(range_err == 1'b1, "R9 time over", 64'(range_err), 64'h1);
    run_hit(12'hFFF, 14'h3FFF, 12'hFFF, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule